// File: doc/BRIEF.md
# Configurable Ratio Sample Demultiplexer

This block spreads a fast stream of 11-bit samples over four slower output ports, A to D, so that the logic behind it can work at a fraction of the input rate. Each sample has a data field of `DATA_W` bits (10 by default) and one extra flag bit that travels with it, for instance to mark an out-of-range conversion. Consecutive samples are placed in the ports in turn. The ratio is 1:4 (ports A to D) or 1:2 (ports A and B only), chosen at run time.

The ports update in one of two ways. In simultaneous mode, every active port updates at once when a group is complete. In staggered mode, each port updates on the edge that captures its own sample, and that port's top bit carries a per-port clock in place of the flag. Samples are captured either on rising edges only, or on both edges of a half-rate clock. A data-ready output marks each completed group, either as a one-cycle pulse or as a level that toggles. An asynchronous active-high reset clears the block. An active-low sleep input freezes all outputs.

Top module: `sample_demux`

## Requirements
- R1: While `arst` is high, all port outputs, `dr` and the slot counter are zero, without waiting for a clock edge. The first sample captured after release goes to port A.
- R2: With `ratio_half`=0, consecutive captured samples fill ports A, B, C, D, then A again. Each port word is {bit DATA_W = flag, bits DATA_W-1:0 = data}.
- R3: With `ratio_half`=1, samples alternate between ports A and B. Ports C and D keep their last value.
- R4: With `stag_n`=1, the active ports all change on the single rising edge that captures the last sample of a group, and at no other time.
- R5: With `stag_n`=0, a port changes on the rising edge that captures its sample. Its bit DATA_W is a port clock that is 0 after reset and inverts on each update of that port.
- R6: With `dual_edge`=0, exactly one sample is taken per rising clock edge.
- R7: With `dual_edge`=1, samples are taken on falling and rising edges, and the first one after reset is taken on the first falling edge. The order in which samples reach the ports equals single-edge mode at twice the clock rate.
- R8: With `dr_toggle`=0, `dr` is high for exactly the cycle that follows the edge on which a group completes.
- R9: With `dr_toggle`=1, `dr` inverts on each edge on which a group completes and is otherwise steady.
- R10: While `sleep_n` is low, ports, `dr` and the slot counter hold. Samples presented during that time are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (full rate, or half rate in dual-edge mode) |
| arst | input | 1 | Asynchronous reset, active high |
| sleep_n | input | 1 | Freeze request, active low |
| stag_n | input | 1 | Staggered update select, active low |
| ratio_half | input | 1 | 1 selects 1:2, 0 selects 1:4 |
| dual_edge | input | 1 | 1 captures on both clock edges |
| dr_toggle | input | 1 | 1 makes data-ready a toggling level |
| din | input | DATA_W | Sample data |
| flag_in | input | 1 | Extra bit carried with each sample |
| port_a | output | DATA_W+1 | Port A word {flag or port clock, data} |
| port_b | output | DATA_W+1 | Port B word |
| port_c | output | DATA_W+1 | Port C word |
| port_d | output | DATA_W+1 | Port D word |
| dr | output | 1 | Data-ready strobe or toggle |

## Verification
The hardest case to reach is dual-edge capture. In that mode the falling-edge sample must be merged ahead of the rising-edge sample, and the first falling edge after reset release must open the sequence. To reach it, the stimulus releases reset while the clock is high and changes `din` shortly after every edge. It then runs all sixteen combinations of ratio, update style, capture edge and data-ready style against one arithmetic model that consumes samples in plain stream order. A sleep window placed in the middle of a group, and a reset raised between clock edges, cover the freeze and asynchronous-clear paths.

// File: rtl/sample_demux_pkg.sv
package sample_demux_pkg;
    localparam int NPORT = 4;
    localparam int IDX_W = $clog2(NPORT);

    typedef enum logic {
        OUT_SIMUL   = 1'b0,
        OUT_STAGGER = 1'b1
    } out_mode_e;
endpackage

// File: rtl/sample_demux_fall_cap.sv
module sample_demux_fall_cap #(
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          arst,
    input  logic [SW-1:0] smp_in,
    output logic [SW-1:0] fall_smp,
    output logic          fall_vld
);
    typedef struct packed {
        logic [SW-1:0] smp;
        logic          vld;
    } fcap_t;

    fcap_t fc_d, fc_q;

    always_comb begin
        fc_d     = fc_q;
        fc_d.smp = smp_in;
        fc_d.vld = 1'b1;
    end

    always_ff @(negedge clk or posedge arst) begin
        if (arst) fc_q <= '0;
        else      fc_q <= fc_d;
    end

    assign fall_smp = fc_q.smp;
    assign fall_vld = fc_q.vld;
endmodule

// File: rtl/sample_demux_core.sv
module sample_demux_core
    import sample_demux_pkg::*;
#(
    parameter int SW = 11
) (
    input  logic                      clk,
    input  logic                      arst,
    input  logic                      sleep_n,
    input  out_mode_e                 omode,
    input  logic                      ratio_half,
    input  logic                      dual_edge,
    input  logic                      dr_toggle,
    input  logic [SW-1:0]             rise_smp,
    input  logic [SW-1:0]             fall_smp,
    input  logic                      fall_vld,
    output logic [NPORT-1:0][SW-1:0]  ports,
    output logic                      dr
);
    localparam int DW = SW - 1;
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(NPORT - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(NPORT / 2 - 1);

    typedef struct packed {
        logic [IDX_W-1:0]           idx;
        logic [NPORT-1:0][SW-1:0]   stg;
        logic [NPORT-1:0][SW-1:0]   port;
        logic [NPORT-1:0]           pclk;
        logic                       dr;
    } dmx_t;

    dmx_t st_d, st_q;

    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] slot;
    logic [SW-1:0]    cur;
    logic             two;
    logic             grp;

    assign last_idx = ratio_half ? LAST_HALF : LAST_FULL;

    always_comb begin
        st_d = st_q;
        slot = '0;
        cur  = '0;
        grp  = 1'b0;
        two  = dual_edge && fall_vld;
        if (sleep_n) begin
            // slot 0 of the pair is the older, falling-edge sample
            for (int j = 0; j < 2; j++) begin
                if (j == 1 || two) begin
                    cur  = (j == 0) ? fall_smp : rise_smp;
                    slot = st_d.idx;
                    if (omode == OUT_STAGGER) begin
                        st_d.pclk[slot] = ~st_d.pclk[slot];
                        st_d.port[slot] = {st_d.pclk[slot], cur[DW-1:0]};
                    end else begin
                        st_d.stg[slot] = cur;
                    end
                    if (slot == last_idx) begin
                        grp      = 1'b1;
                        st_d.idx = '0;
                        if (omode == OUT_SIMUL) begin
                            for (int p = 0; p < NPORT; p++) begin
                                if (IDX_W'(p) <= last_idx) st_d.port[p] = st_d.stg[p];
                            end
                        end
                    end else begin
                        st_d.idx = slot + IDX_W'(1);
                    end
                end
            end
            st_d.dr = dr_toggle ? (st_q.dr ^ grp) : grp;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign ports = st_q.port;
    assign dr    = st_q.dr;
endmodule

// File: rtl/sample_demux.sv
module sample_demux
    import sample_demux_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              sleep_n,
    input  logic              stag_n,
    input  logic              ratio_half,
    input  logic              dual_edge,
    input  logic              dr_toggle,
    input  logic [DATA_W-1:0] din,
    input  logic              flag_in,
    output logic [DATA_W:0]   port_a,
    output logic [DATA_W:0]   port_b,
    output logic [DATA_W:0]   port_c,
    output logic [DATA_W:0]   port_d,
    output logic              dr
);
    localparam int SW = DATA_W + 1;

    logic [SW-1:0]            rise_smp;
    logic [SW-1:0]            fall_smp;
    logic                     fall_vld;
    logic [NPORT-1:0][SW-1:0] ports;
    out_mode_e                omode;

    assign rise_smp = {flag_in, din};
    assign omode    = stag_n ? OUT_SIMUL : OUT_STAGGER;

    sample_demux_fall_cap #(.SW(SW)) fcap_i (
        .clk      (clk),
        .arst     (arst),
        .smp_in   (rise_smp),
        .fall_smp (fall_smp),
        .fall_vld (fall_vld)
    );

    sample_demux_core #(.SW(SW)) core_i (
        .clk        (clk),
        .arst       (arst),
        .sleep_n    (sleep_n),
        .omode      (omode),
        .ratio_half (ratio_half),
        .dual_edge  (dual_edge),
        .dr_toggle  (dr_toggle),
        .rise_smp   (rise_smp),
        .fall_smp   (fall_smp),
        .fall_vld   (fall_vld),
        .ports      (ports),
        .dr         (dr)
    );

    assign port_a = ports[0];
    assign port_b = ports[1];
    assign port_c = ports[2];
    assign port_d = ports[3];
endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk #(
    parameter int DATA_W = 10
) (
    input logic            clk,
    input logic            arst,
    input logic            sleep_n,
    input logic            stag_n,
    input logic            ratio_half,
    input logic            dual_edge,
    input logic            dr_toggle,
    input logic [DATA_W:0] port_a,
    input logic [DATA_W:0] port_b,
    input logic [DATA_W:0] port_c,
    input logic [DATA_W:0] port_d,
    input logic            dr
);
    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (arst)
        !sleep_n |=> ($stable(port_a) && $stable(port_b) && $stable(port_c)
                      && $stable(port_d) && $stable(dr)));

    // R3
    half_cd_hold_chk: assert property (@(posedge clk) disable iff (arst)
        ratio_half |=> ($stable(port_c) && $stable(port_d)));

    // R5
    stagger_one_port_chk: assert property (@(posedge clk) disable iff (arst)
        (!stag_n && !dual_edge) |=>
            ($countones({port_a != $past(port_a), port_b != $past(port_b),
                         port_c != $past(port_c), port_d != $past(port_d)}) <= 1));

    // R8
    dr_pulse_single_chk: assert property (@(posedge clk) disable iff (arst)
        (!dr_toggle && !dual_edge && !ratio_half && sleep_n && dr) |=> !dr);

    // R4
    simul_with_dr_chk: assert property (@(posedge clk) disable iff (arst)
        (stag_n && !dr_toggle) |=> ((port_a == $past(port_a)) || dr));
endmodule

bind sample_demux sample_demux_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .arst       (arst),
    .sleep_n    (sleep_n),
    .stag_n     (stag_n),
    .ratio_half (ratio_half),
    .dual_edge  (dual_edge),
    .dr_toggle  (dr_toggle),
    .port_a     (port_a),
    .port_b     (port_b),
    .port_c     (port_c),
    .port_d     (port_d),
    .dr         (dr)
);

// File: tb/sample_demux_tb_top.sv
`timescale 1ns/100ps
module sample_demux_tb_top;
    localparam int DW = 10;
    localparam int NCYC = 14;

    logic          clk = 1'b0;
    logic          arst = 1'b1;
    logic          sleep_n = 1'b1;
    logic          stag_n = 1'b1;
    logic          ratio_half = 1'b0;
    logic          dual_edge = 1'b0;
    logic          dr_toggle = 1'b0;
    logic [DW-1:0] din = '0;
    logic          flag_in = 1'b0;
    logic [DW:0]   port_a, port_b, port_c, port_d;
    logic          dr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [DW:0] e_port [4];
    logic [DW:0] e_stg  [4];
    logic        e_pclk [4];
    logic        e_dr;
    logic        e_grp;
    int          e_cnt;

    always #2 clk = ~clk;

    sample_demux #(.DATA_W(DW)) dut_i (
        .clk(clk), .arst(arst), .sleep_n(sleep_n), .stag_n(stag_n),
        .ratio_half(ratio_half), .dual_edge(dual_edge), .dr_toggle(dr_toggle),
        .din(din), .flag_in(flag_in),
        .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d), .dr(dr)
    );

    function automatic logic [DW:0] smp(int k);
        logic [31:0] kv;
        kv = k;
        return {kv[1] ^ kv[3], DW'((k * 37 + 11) % 1024)};
    endfunction

    task automatic chk(string tag, logic [DW:0] act, logic [DW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            e_port[i] = '0; e_stg[i] = '0; e_pclk[i] = 1'b0;
        end
        e_dr = 1'b0; e_cnt = 0; e_grp = 1'b0;
    endtask

    task automatic model_push(logic [DW:0] s);
        int g, pos;
        g   = ratio_half ? 2 : 4;
        pos = e_cnt % g;
        if (!stag_n) begin
            e_pclk[pos] = ~e_pclk[pos];
            e_port[pos] = {e_pclk[pos], s[DW-1:0]};
        end else begin
            e_stg[pos] = s;
        end
        if (pos == g - 1) begin
            e_grp = 1'b1;
            if (stag_n) for (int i = 0; i < g; i++) e_port[i] = e_stg[i];
        end
        e_cnt++;
    endtask

    task automatic check_all(string ctx);
        string tm, tcd, tdr;
        tm  = stag_n ? "R4" : "R5";
        tcd = ratio_half ? "R3" : "R2";
        tdr = dr_toggle ? "R9" : "R8";
        chk($sformatf("%s R2 %s port_a", ctx, tm), port_a, e_port[0]);
        chk($sformatf("%s R2 %s port_b", ctx, tm), port_b, e_port[1]);
        chk($sformatf("%s %s %s port_c", ctx, tcd, tm), port_c, e_port[2]);
        chk($sformatf("%s %s %s port_d", ctx, tcd, tm), port_d, e_port[3]);
        chk($sformatf("%s %s dr", ctx, tdr), {{DW{1'b0}}, dr}, {{DW{1'b0}}, e_dr});
    endtask

    task automatic run_config(bit half, bit stg, bit dual, bit drt);
        int  kk;
        bit  slp;
        bit  with_sleep;
        string ctx;
        logic [DW:0] v;
        ratio_half = half; stag_n = !stg; dual_edge = dual; dr_toggle = drt;
        ctx = $sformatf("cfg h%0d s%0d d%0d t%0d %s", half, stg, dual, drt, dual ? "R7" : "R6");
        with_sleep = !dual;
        model_reset();
        @(posedge clk); #1;
        check_all({ctx, " R1 reset"});
        kk = 0;
        arst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            slp = with_sleep && c >= 5 && c < 9;
            sleep_n = !slp;
            v = slp ? {1'b1, {DW{1'b1}}} : smp(kk);
            {flag_in, din} = v;
            if (dual) begin
                @(negedge clk); #1;
                {flag_in, din} = smp(kk + 1);
            end
            @(posedge clk); #1;
            e_grp = 1'b0;
            if (!slp) begin
                if (dual) begin
                    model_push(smp(kk)); model_push(smp(kk + 1)); kk += 2;
                end else begin
                    model_push(smp(kk)); kk += 1;
                end
                e_dr = drt ? (e_dr ^ e_grp) : e_grp;
            end
            check_all(slp ? {ctx, " R10 sleep"} : ctx);
        end
        sleep_n = 1'b1;
        // asynchronous clear between edges
        @(negedge clk); #1;
        arst = 1'b1;
        #0.5;
        model_reset();
        check_all({ctx, " R1 async"});
    endtask

    initial begin
        model_reset();
        for (int cfg = 0; cfg < 16; cfg++) begin
            run_config(cfg[0], cfg[1], cfg[2], cfg[3]);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule